// File: doc/BRIEF.md
# Link Reset Bring-up Sequencer

This controller performs the reset choreography that brings a serial link port out of reset after a start request. It drives three active-high resets, for the transaction layer, the PHY-side pipe interface and the internal bus interface, plus an active-low fundamental reset for the endpoint. On start, all four are asserted together. The three local resets are then dropped first, so the physical layer comes up and drives the reference clock while the endpoint is still held in reset. After a settle interval, the endpoint reset is released.

After a further fixed wait, the controller polls a link-up input at a regular interval, bounded by a poll window. The first high sample produces a one-cycle done pulse, and the port is then left running. If the window runs out first, the controller latches the training-state status word, raises an error flag and reasserts every reset. Every interval is a parameter counted in clock cycles. The defaults assume a 125 MHz clock: 1 us hold, 100 ms settle, 100 ms post-release wait, 20 us poll interval and 50 ms poll window.

Top module: `link_bringup_seq`

## Requirements
- R1: `rst_n` is synchronous and active low. After any clock edge that samples it low, `tl_rst`, `pipe_rst` and `bus_rst` are 1, `perst_n` is 0, `done` and `err` are 0 and `fail_state` is 0. With no start, these values persist after reset is released.
- R2: Call the edge that accepts a start E0. Start is accepted in the idle, running or error state. The three local resets are 1 after edges E0 through E0+HOLD_CYC-1 and drop to 0 at edge E0+HOLD_CYC.
- R3: `perst_n` rises at edge E0+HOLD_CYC+SETTLE_CYC. While `perst_n` is 1, all three local resets are 0.
- R4: A high `link_up` seen before edge Q = E0+HOLD_CYC+SETTLE_CYC+POST_CYC has no effect. The post-release wait always runs its full length.
- R5: `link_up` is sampled only at edges Q+k*POLL_IV_CYC for k >= 1. At the first such edge with `link_up` high, `done` goes to 1 for exactly one cycle.
- R6: After success, the local resets stay 0 and `perst_n` stays 1 until the next start is accepted.
- R7: If no sample is high by edge Q+POLL_MAX_CYC, `err` becomes 1 at that edge. `fail_state` captures `ltssm_state` as sampled at that edge, all four resets are asserted again, and these values are held until the next start. A high sample that falls on that same edge counts as success.
- R8: A start raised while a sequence is running, between acceptance and done or error, changes no timing.
- R9: A start accepted in the error state clears `err` and `fail_state` to 0 at its acceptance edge and reruns the whole sequence from R2.
- R10: The three local resets always carry identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| start | input | 1 | Bring-up request, sampled each edge |
| link_up | input | 1 | Link-up indication |
| ltssm_state | input | SW | Training-state status word |
| tl_rst | output | 1 | Transaction-layer reset, active high |
| pipe_rst | output | 1 | PHY-side pipe interface reset, active high |
| bus_rst | output | 1 | Internal bus interface reset, active high |
| perst_n | output | 1 | Endpoint fundamental reset, active low |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Poll window expired without link-up |
| fail_state | output | SW | Status word captured on failure |

## Verification
The assertions assume that `start`, `link_up` and `ltssm_state` are synchronous to `clk` and settled before each rising edge. They also assume that `rst_n` is held low for at least two edges at power-up, so the registered history that `$past` reads is defined. The bench changes every input only on the falling edge. It holds `ltssm_state` constant through each run, so the captured value is unambiguous, and it keeps reset low for three cycles before the first start.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ASSERT = 3'd1,
    ST_SETTLE = 3'd2,
    ST_POST   = 3'd3,
    ST_POLL   = 3'd4,
    ST_UP     = 3'd5,
    ST_ERR    = 3'd6
  } lrb_state_e;
endpackage

// File: rtl/lrb_delay.sv
`timescale 1ns/1ps
// Loadable down counter; zero flag is a pure decode of the register.
module lrb_delay #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);

  // an expired counter stays expired until reloaded (R2, R3 timing base)
  p_zero_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/lrb_fsm.sv
`timescale 1ns/1ps
module lrb_fsm
  import lrb_pkg::*;
#(
  parameter int CW           = 24,
  parameter int HOLD_CYC     = 125,
  parameter int SETTLE_CYC   = 12500000,
  parameter int POST_CYC     = 12500000,
  parameter int POLL_MAX_CYC = 6250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          link_up,
  input  logic          main_zero,
  input  logic          iv_zero,
  output logic          main_load,
  output logic [CW-1:0] main_val,
  output logic          iv_load,
  output logic          launch,
  output logic          fail_evt,
  output logic          grp_rst,
  output logic          perst_n,
  output logic          done
);
  lrb_state_e state, nxt;
  logic       win;

  always_comb begin
    nxt       = state;
    main_load = 1'b0;
    main_val  = '0;
    iv_load   = 1'b0;
    launch    = 1'b0;
    fail_evt  = 1'b0;
    win       = 1'b0;
    unique case (state)
      ST_IDLE, ST_UP, ST_ERR: begin
        if (start) begin
          nxt       = ST_ASSERT;
          main_load = 1'b1;
          main_val  = CW'(HOLD_CYC - 1);
          launch    = 1'b1;
        end
      end
      ST_ASSERT: begin
        if (main_zero) begin
          nxt       = ST_SETTLE;
          main_load = 1'b1;
          main_val  = CW'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (main_zero) begin
          nxt       = ST_POST;
          main_load = 1'b1;
          main_val  = CW'(POST_CYC - 1);
        end
      end
      ST_POST: begin
        // link_up deliberately not examined here
        if (main_zero) begin
          nxt       = ST_POLL;
          main_load = 1'b1;
          main_val  = CW'(POLL_MAX_CYC - 1);
          iv_load   = 1'b1;
        end
      end
      ST_POLL: begin
        if (iv_zero && link_up) begin
          nxt = ST_UP;
          win = 1'b1;
        end else if (main_zero) begin
          nxt      = ST_ERR;
          fail_evt = 1'b1;
        end else if (iv_zero) begin
          iv_load = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      grp_rst <= 1'b1;
      perst_n <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= nxt;
      grp_rst <= (nxt == ST_IDLE) || (nxt == ST_ASSERT) || (nxt == ST_ERR);
      perst_n <= (nxt == ST_POST) || (nxt == ST_POLL) || (nxt == ST_UP);
      done    <= win;
    end
  end

  // start during a running sequence never restarts it
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SETTLE) || (state == ST_POST) || (state == ST_POLL)) && start
    |=> (state != ST_ASSERT));

  // a successful port stays up without a new start
  p_up_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UP) && !start |=> (state == ST_UP));

  // post-release wait is never cut short by link_up
  p_post_full_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST) && !main_zero |=> (state == ST_POST));
endmodule

// File: rtl/lrb_fail_cap.sv
`timescale 1ns/1ps
module lrb_fail_cap #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          fail_evt,
  input  logic [SW-1:0] ltssm_state,
  output logic          err,
  output logic [SW-1:0] fail_state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err        <= 1'b0;
      fail_state <= '0;
    end else if (fail_evt) begin
      err        <= 1'b1;
      fail_state <= ltssm_state;
    end else if (launch) begin
      err        <= 1'b0;
      fail_state <= '0;
    end
  end

  p_clear_on_launch_r9: assert property (@(posedge clk) disable iff (rst)
    launch |=> (!err && (fail_state == '0)));

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    fail_evt |=> (err && (fail_state == $past(ltssm_state))));
endmodule

// File: rtl/link_bringup_seq.sv
`timescale 1ns/1ps
module link_bringup_seq #(
  parameter int SW           = 6,
  parameter int HOLD_CYC     = 125,
  parameter int SETTLE_CYC   = 12500000,
  parameter int POST_CYC     = 12500000,
  parameter int POLL_IV_CYC  = 2500,
  parameter int POLL_MAX_CYC = 6250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_up,
  input  logic [SW-1:0] ltssm_state,
  output logic          tl_rst,
  output logic          pipe_rst,
  output logic          bus_rst,
  output logic          perst_n,
  output logic          done,
  output logic          err,
  output logic [SW-1:0] fail_state
);
  localparam int MX_A = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int MX_B = (POST_CYC > POLL_MAX_CYC) ? POST_CYC : POLL_MAX_CYC;
  localparam int MX   = (MX_A > MX_B) ? MX_A : MX_B;
  localparam int CW   = $clog2(MX + 1);
  localparam int IW   = $clog2(POLL_IV_CYC + 1);

  logic          rst;
  logic          main_load, main_zero, iv_load, iv_zero;
  logic [CW-1:0] main_val;
  logic          launch, fail_evt, grp_rst;

  assign rst = ~rst_n;

  lrb_delay #(.W(CW)) u_main (
    .clk(clk), .rst(rst), .load(main_load), .load_val(main_val), .zero(main_zero)
  );

  lrb_delay #(.W(IW)) u_iv (
    .clk(clk), .rst(rst), .load(iv_load), .load_val(IW'(POLL_IV_CYC - 1)),
    .zero(iv_zero)
  );

  lrb_fsm #(
    .CW(CW), .HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC),
    .POST_CYC(POST_CYC), .POLL_MAX_CYC(POLL_MAX_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .link_up(link_up),
    .main_zero(main_zero), .iv_zero(iv_zero),
    .main_load(main_load), .main_val(main_val), .iv_load(iv_load),
    .launch(launch), .fail_evt(fail_evt),
    .grp_rst(grp_rst), .perst_n(perst_n), .done(done)
  );

  lrb_fail_cap #(.SW(SW)) u_cap (
    .clk(clk), .rst(rst), .launch(launch), .fail_evt(fail_evt),
    .ltssm_state(ltssm_state), .err(err), .fail_state(fail_state)
  );

  assign tl_rst   = grp_rst;
  assign pipe_rst = grp_rst;
  assign bus_rst  = grp_rst;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (tl_rst && !perst_n && !done && !err && (fail_state == '0)));

  p_perst_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    perst_n |-> !tl_rst);

  p_perst_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n) |-> $past(!bus_rst));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (perst_n && !tl_rst && !err));

  p_err_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pipe_rst && !perst_n));

  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(err)) |-> $stable(fail_state));
endmodule

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;
  localparam int SW = 6;
  localparam int H  = 4;
  localparam int S  = 10;
  localparam int P  = 12;
  localparam int IV = 3;
  localparam int M  = 15;
  localparam int Q  = H + S + P;   // 26: first cycle of polling
  localparam int NV = 7;
  localparam int RUNLEN = Q + M + 3;

  // link_up rise offset, expected done offset (-1 = timeout), mid-run start, status word
  localparam int VL  [NV] = '{1, 30, 38, 1000, 41, 32, 42};
  localparam int VSE [NV] = '{29, 32, 38, -1, 41, 32, -1};
  localparam int VMID[NV] = '{0, 0, 0, 0, 0, 1, 0};
  localparam int VLT [NV] = '{3, 4, 5, 21, 7, 9, 42};

  logic          clk = 1'b0;
  logic          rst_n, start, link_up;
  logic [SW-1:0] ltssm_state;
  logic          tl_rst, pipe_rst, bus_rst, perst_n, done, err;
  logic [SW-1:0] fail_state;

  int checks = 0;
  int fails  = 0;
  bit fin    = 0;
  bit prev_err = 0;

  always #4 clk = ~clk;

  link_bringup_seq #(
    .SW(SW), .HOLD_CYC(H), .SETTLE_CYC(S), .POST_CYC(P),
    .POLL_IV_CYC(IV), .POLL_MAX_CYC(M)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
    .ltssm_state(ltssm_state), .tl_rst(tl_rst), .pipe_rst(pipe_rst),
    .bus_rst(bus_rst), .perst_n(perst_n), .done(done), .err(err),
    .fail_state(fail_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all_asserted(input string req);
    chk(req, tl_rst, 1);
    chk(req, pipe_rst, 1);
    chk(req, bus_rst, 1);
    chk(req, perst_n, 0);
    chk(req, done, 0);
    chk(req, err, 0);
    chk(req, fail_state, 0);
  endtask

  task automatic run_vec(input int v);
    int  se;
    bit  ok;
    ok = (VSE[v] >= 0);
    se = VSE[v];
    ltssm_state = SW'(VLT[v]);
    link_up = 1'b0;
    start   = 1'b1;
    @(negedge clk);            // edge E0 accepted start
    start = 1'b0;
    for (int n = 0; n < RUNLEN; n++) begin
      int e_rst, e_perst, e_done, e_err, e_fs;
      e_rst   = ok ? (n < H) : ((n < H) || (n >= Q + M));
      e_perst = ok ? (n >= H + S) : ((n >= H + S) && (n < Q + M));
      e_done  = (ok && n == se) ? 1 : 0;
      e_err   = (!ok && n >= Q + M) ? 1 : 0;
      e_fs    = e_err ? VLT[v] : 0;
      // R2 release timing, R6 hold after success, R8 mid-run start
      chk(VMID[v] != 0 ? "R8" : (ok && n > se) ? "R6" : "R2", tl_rst, e_rst);
      chk("R10", pipe_rst, tl_rst);        // R10 group equality
      chk("R10", bus_rst, tl_rst);
      chk((ok && n > se) ? "R6" : "R3", perst_n, e_perst);
      // R4: vector 0 raises link_up during the post-release wait
      chk(v == 0 ? "R4" : "R5", done, e_done);
      chk((n == 0 && prev_err) ? "R9" : "R7", err, e_err);
      chk((n == 0 && prev_err) ? "R9" : "R7", fail_state, e_fs);
      link_up = ((n + 1) >= VL[v]);
      start   = (VMID[v] != 0) && ((n + 1) == 5 || (n + 1) == Q + 2);
      @(negedge clk);
    end
    prev_err = !ok;
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    link_up = 1'b0;
    ltssm_state = '0;
    repeat (3) @(negedge clk);
    chk_all_asserted("R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all_asserted("R1");      // idle without start keeps everything in reset

    for (int v = 0; v < NV; v++) run_vec(v);

    // R1: system reset clears a latched error
    rst_n = 1'b0;
    @(negedge clk);
    chk_all_asserted("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset in the middle of polling reasserts everything at once
    link_up = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (Q) @(negedge clk);
    chk("R3", perst_n, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all_asserted("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all_asserted("R1");

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule